// File: doc/BRIEF.md
# Configuration Header Sync Detector

This block examines the first words of a configuration image as they stream in and decides two things. The first is whether the image opens with the expected thirteen-word preamble. The second is whether each 32-bit word of the image is stored byte-reversed.

A one-cycle start strobe arms the checker. The checker then consumes header words one at a time from a valid/ready input. It stops at the first word that disagrees with the preamble. On a decision it raises a one-cycle done pulse together with a sticky header-ok flag and a sticky swap flag.

When the header is accepted, the block emits the thirteen header words in normalised byte order on its output stream. It then forwards every payload word, byte-reversed when swapping was detected, with downstream backpressure applied. A rejected image is drained silently until the next start strobe.

Top module: `cfg_hdr_sync_det`

## Requirements
- R1: A synchronous active-high reset returns the block to idle: done_o, hdr_ok_o, swap_o and out_valid_o low, and in_ready_o high, so that words arriving before any start strobe are consumed and produce no output.
- R2: The preamble is thirteen words. Positions 0-7, 10 and 11 hold 0xFFFFFFFF, position 8 holds 0x000000BB, position 9 holds 0x11220044 and position 12 holds 0xAA995566. An image matching all thirteen in normal order gives done_o high for exactly one cycle, in the cycle after word 12 is accepted, with hdr_ok_o=1 and swap_o=0.
- R3: A non-padding header word whose byte-reversed form equals the expected word latches swap_o=1 and counts as a match, so a fully byte-reversed header is accepted with swap_o=1.
- R4: A word at an all-ones position never sets swap_o. A header rejected at or before position 8 reports swap_o=0.
- R5: Once swap_o is set, every later word is byte-reversed before it is compared. A word 9 sent in normal order after a reversed word 8 is rejected, with swap_o=1.
- R6: At the first mismatching header word, done_o pulses in the following cycle with hdr_ok_o=0. From then on, input words are accepted and discarded with no output until the next start strobe.
- R7: After an accepted header, the output carries the thirteen preamble values of R2 in order, followed by exactly one output word per payload input word, in order.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value. During payload, in_ready_o follows out_ready_i.
- R9: start_i restarts the check at header position 0 from any state and clears hdr_ok_o and swap_o. in_ready_o is low in any cycle in which start_i is high.
- R10: Byte reversal puts input bits [7:0] in output bits [31:24] and input bits [31:24] in output bits [7:0], for example 0x01020304 becomes 0x04030201.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-image strobe, arms the header check |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input word |
| in_ready_o | output | 1 | Input word accepted when high with in_valid_i |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output word, byte-order normalised |
| out_ready_i | input | 1 | Downstream ready |
| done_o | output | 1 | One-cycle pulse when the header decision is made |
| hdr_ok_o | output | 1 | Header accepted, held until the next start or reset |
| swap_o | output | 1 | Byte-reversed image detected, held until the next start or reset |

## Verification
Faults in the header position counter appear on the very next decision. The done pulse comes one word early or late, or a good image is rejected, and the bench checks done_o in the exact cycle after the deciding word. A swap flag latched at the wrong moment shows up in three places: swap_o read back at the decision, the verdict on mixed-order images, and the byte order of every forwarded payload word. Replay or pass-through faults show as a wrong word, a missing word or an extra word on the output stream, which is compared against a model queue while the downstream ready toggles at random.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int WORD_W    = 32;
  localparam int HDR_LEN   = 13;
  localparam int HDR_IDX_W = $clog2(HDR_LEN);
  localparam logic [WORD_W-1:0] PAD_WORD = '1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_REPLAY = 2'd2,
    ST_PASS   = 2'd3
  } seq_st_e;

  // Reverse the byte lanes of one word: lane b moves to lane 3-b.
  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W/8; b++) begin
      r[8*b +: 8] = w[8*(WORD_W/8-1-b) +: 8];
    end
    return r;
  endfunction

  // Expected preamble value at a given position, in normal byte order.
  function automatic logic [WORD_W-1:0] hdr_word(input logic [HDR_IDX_W-1:0] idx);
    logic [WORD_W-1:0] v;
    case (idx)
      HDR_IDX_W'(8):  v = 32'h0000_00BB;
      HDR_IDX_W'(9):  v = 32'h1122_0044;
      HDR_IDX_W'(12): v = 32'hAA99_5566;
      default:        v = PAD_WORD;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/hdr_word_cmp.sv
module hdr_word_cmp
  import cfg_hdr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] expect_i,
  input  logic              swap_i,
  output logic              swap_hit_o,
  output logic              match_o
);
  logic [WORD_W-1:0] rev_w;
  logic [WORD_W-1:0] norm_w;
  logic              pad_pos_w;

  assign rev_w      = byte_rev(word_i);
  assign pad_pos_w  = (expect_i == PAD_WORD);
  // Only a non-padding word can reveal the byte order (R3, R4).
  assign swap_hit_o = !swap_i && !pad_pos_w && (rev_w == expect_i);
  assign norm_w     = (swap_i || swap_hit_o) ? rev_w : word_i;
  assign match_o    = (norm_w == expect_i);
endmodule

// File: rtl/hdr_seq_ctrl.sv
module hdr_seq_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 start_i,
  input  logic                 in_valid_i,
  input  logic                 out_ready_i,
  input  logic                 cmp_match_i,
  input  logic                 cmp_swap_hit_i,
  output seq_st_e              st_o,
  output logic [HDR_IDX_W-1:0] idx_o,
  output logic                 in_ready_o,
  output logic                 done_o,
  output logic                 ok_o,
  output logic                 swap_o
);
  localparam logic [HDR_IDX_W-1:0] LAST_IDX = HDR_IDX_W'(HDR_LEN - 1);

  seq_st_e              st_q;
  logic [HDR_IDX_W-1:0] idx_q;
  logic                 done_q, ok_q, sw_q;
  logic                 accept_w;
  logic                 last_w;

  assign in_ready_o = !start_i && ((st_q == ST_IDLE) || (st_q == ST_CHECK) ||
                                   ((st_q == ST_PASS) && out_ready_i));
  assign accept_w   = in_valid_i && in_ready_o;
  assign last_w     = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      sw_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        st_q  <= ST_CHECK;
        idx_q <= '0;
        ok_q  <= 1'b0;
        sw_q  <= 1'b0;
      end else begin
        case (st_q)
          ST_CHECK: if (accept_w) begin
            if (cmp_swap_hit_i) sw_q <= 1'b1;
            if (!cmp_match_i) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else if (last_w) begin
              done_q <= 1'b1;
              ok_q   <= 1'b1;
              st_q   <= ST_REPLAY;
              idx_q  <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_REPLAY: if (out_ready_i) begin
            if (last_w) st_q <= ST_PASS;
            else        idx_q <= idx_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign st_o   = st_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign swap_o = sw_q;

  // R2/R6: the decision is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);
  // R2: acceptance only ever appears together with the decision pulse
  p_ok_with_done_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ok_o) |-> done_o);
  // R5: the swap state is sticky until a new start
  p_swap_sticky_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (swap_o && !start_i) |=> swap_o);
  // R9: a start strobe clears the result flags
  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |=> (!ok_o && !swap_o && !done_o));
  // R1: reset clears the result flags
  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (!done_o && !ok_o && !swap_o && in_ready_o == !start_i));
endmodule

// File: rtl/cfg_hdr_sync_det.sv
module cfg_hdr_sync_det
  import cfg_hdr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              done_o,
  output logic              hdr_ok_o,
  output logic              swap_o
);
  seq_st_e              st_w;
  logic [HDR_IDX_W-1:0] idx_w;
  logic [WORD_W-1:0]    expect_w;
  logic                 match_w, swap_hit_w;

  assign expect_w = hdr_word(idx_w);

  hdr_word_cmp u_cmp (
    .word_i     (in_data_i),
    .expect_i   (expect_w),
    .swap_i     (swap_o),
    .swap_hit_o (swap_hit_w),
    .match_o    (match_w)
  );

  hdr_seq_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .start_i        (start_i),
    .in_valid_i     (in_valid_i),
    .out_ready_i    (out_ready_i),
    .cmp_match_i    (match_w),
    .cmp_swap_hit_i (swap_hit_w),
    .st_o           (st_w),
    .idx_o          (idx_w),
    .in_ready_o     (in_ready_o),
    .done_o         (done_o),
    .ok_o           (hdr_ok_o),
    .swap_o         (swap_o)
  );

  // Header words are replayed from the constants; payload passes through.
  assign out_valid_o = (st_w == ST_REPLAY) || ((st_w == ST_PASS) && in_valid_i && !start_i);
  assign out_data_o  = (st_w == ST_REPLAY) ? expect_w
                     : (swap_o ? byte_rev(in_data_i) : in_data_i);

  // R6: a rejected image produces no output
  p_reject_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && !hdr_ok_o) |-> !out_valid_o);
  // R8: replayed header words hold under backpressure
  p_replay_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    ((st_w == ST_REPLAY) && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o)));
  // R7: header replay begins only after an accepted header
  p_replay_needs_ok_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_w == ST_REPLAY) |-> hdr_ok_o);
endmodule

// File: tb/cfg_hdr_sync_det_tb_top.sv
module cfg_hdr_sync_det_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic        done, hdr_ok, swap;

  int n_chk = 0;
  int n_fail = 0;
  bit rand_ready = 1'b0;
  bit prev_stall = 1'b0;
  logic [31:0] prev_data = '0;
  logic [31:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_sync_det dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .done_o(done), .hdr_ok_o(hdr_ok), .swap_o(swap)
  );

  function automatic logic [31:0] tb_rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] tb_hdr(input int i);
    if (i == 8)  return 32'h0000_00BB;
    if (i == 9)  return 32'h1122_0044;
    if (i == 12) return 32'hAA99_5566;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) out_ready <= rand_ready ? (($urandom % 4) != 0) : 1'b1;

  // Output monitor, sampling just before the rising edge
  always begin
    @(negedge clk);
    #4;
    if (!rst) begin
      if (prev_stall) begin
        chk(out_valid && out_data == prev_data, "R8 hold under stall", out_data, prev_data);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R6/R7 unexpected output word", out_data, 32'h0);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(out_data == e, "R7/R10 output word", out_data, e);
        end
      end
    end
  end

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      bit acc;
      #4;
      acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R9 in_ready low with start", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    start = 1'b0;
    chk(!hdr_ok && !swap && !done, "R9 flags cleared by start", {29'b0, done, hdr_ok, swap}, 32'h0);
  endtask

  // mode: 0 plain, 1 word 9 sent in normal order after a reversed word 8
  task automatic run_image(input bit swapped, input int bad, input int mode, input int npay,
                           input bit fixed_pay);
    bit accepted = 1'b0;
    do_start();
    for (int i = 0; i < 13; i++) begin
      logic [31:0] raw;
      bit decide;
      raw = swapped ? tb_rev(tb_hdr(i)) : tb_hdr(i);
      if (i == bad) raw = raw ^ 32'h1;
      if (mode == 1 && i == 9) raw = tb_hdr(9);
      decide = (i == bad) || (i == 12) || (mode == 1 && i == 9);
      send(raw);
      if (decide) begin
        bit exp_ok, exp_sw;
        exp_ok = (i == 12) && (bad != 12) && (mode == 0);
        exp_sw = swapped && (i > 8);
        chk(done == 1'b1, "R2/R6 done pulse timing", {31'b0, done}, 32'h1);
        chk(hdr_ok == exp_ok, "R2/R6 header verdict", {31'b0, hdr_ok}, {31'b0, exp_ok});
        chk(swap == exp_sw, "R3/R4/R5 swap flag", {31'b0, swap}, {31'b0, exp_sw});
        accepted = exp_ok;
        if (accepted) for (int k = 0; k < 13; k++) expq.push_back(tb_hdr(k));
        @(negedge clk);
        chk(done == 1'b0, "R2/R6 done lasts one cycle", {31'b0, done}, 32'h0);
        break;
      end
    end
    for (int p = 0; p < npay; p++) begin
      logic [31:0] w;
      w = fixed_pay ? 32'h0102_0304 : $urandom;
      if (accepted) begin
        if (fixed_pay && swapped) expq.push_back(32'h0403_0201);  // R10
        else expq.push_back(swapped ? tb_rev(w) : w);
      end
      send(w);
    end
    for (int c = 0; c < 300 && expq.size() != 0; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R7 all words forwarded", expq.size(), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!done && !hdr_ok && !swap && !out_valid, "R1 reset outputs", {28'b0, done, hdr_ok, swap, out_valid}, 32'h0);
    chk(in_ready == 1'b1, "R1 idle accepts input", {31'b0, in_ready}, 32'h1);
    send(32'hFFFF_FFFF);
    send(32'h0000_00BB);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0 && !done, "R1 idle words ignored", {31'b0, done}, 32'h0);

    run_image(1'b0, -1, 0, 4, 1'b0);           // R2 normal order
    run_image(1'b1, -1, 0, 3, 1'b1);           // R3, R10 reversed image
    run_image(1'b1, 8, 0, 3, 1'b0);            // R4 reject at word 8, no swap
    run_image(1'b1, 3, 0, 2, 1'b0);            // R4 reject in padding
    run_image(1'b1, -1, 1, 3, 1'b0);           // R5 mixed order rejected
    run_image(1'b0, 12, 0, 3, 1'b0);           // R6 reject at last word
    // R9: restart in the middle of a header
    do_start();
    for (int i = 0; i < 5; i++) send(32'hFFFF_FFFF);
    run_image(1'b0, -1, 0, 2, 1'b0);

    rand_ready = 1'b1;                          // R8 backpressure
    for (int n = 0; n < 40; n++) begin
      int bad;
      bad = (($urandom % 3) == 0) ? int'($urandom % 13) : -1;
      run_image(1'($urandom % 2), bad, 0, int'($urandom % 9), 1'b0);
    end
    rand_ready = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule